// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block carries 18-bit words from a producer on one clock to a consumer on a second, unrelated clock. Each side has an enable and a read/write select. The producer side stores a word when its access is a write. The consumer side takes the oldest word when its access is a read. Storage depth is a power-of-two parameter, normally 256 or 512 words.

Two active-low warning flags tell each side how close the queue is to a limit. The almost-empty flag lives in the consumer's clock domain. It is low while the stored count is at or below a static threshold `n`. The almost-full flag lives in the producer's clock domain. It is low once the count reaches the depth minus a static threshold `m`.

Each side updates its own flag at once for its own accesses. A change caused by the opposite side arrives through a Gray-coded pointer and a two-stage synchroniser, so it shows up a fixed few edges later. If the two clock edges fall close together, that change slips by one more edge.

Top module: `dcfifo_ab`

## Requirements
- R1: A word is stored only on a rising `clk_a` edge where `en_a`=1 and `rnw_a`=0. An access with `rnw_a`=1 stores nothing.
- R2: On a rising `clk_b` edge where `en_b`=1 and `rnw_b`=1, the oldest stored word is removed. That word appears on `dout_b` after that edge. Words leave in the order they were stored.
- R3: A write attempted while `DEPTH` words are stored is dropped. It changes neither the contents nor the order of the stored words.
- R4: A read attempted while no word is stored is dropped. `dout_b` keeps its previous value.
- R5: Once the crossing latency has passed, `ae_n` is 0 when the stored count is at most `ofs_ae`, and 1 when the count is at least `ofs_ae`+1.
- R6: Once the crossing latency has passed, `af_n` is 0 when the stored count is at least `DEPTH`-`ofs_af`, and 1 when the count is at most `DEPTH`-`ofs_af`-1.
- R7: A side's own access changes its flag on the same edge that performs the access. A write updates `af_n` at that `clk_a` edge. A read updates `ae_n` at that `clk_b` edge.
- R8: Pointers cross between clock domains as Gray codes, changing at most one bit per edge. A flag change caused by the opposite side takes effect on the third or fourth rising edge of the flag's own clock after the access.
- R9: While `rst_n` is 0 (asynchronous reset), the FIFO is empty, `ae_n` is 0 and `af_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Producer-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| en_a | input | 1 | Producer access enable |
| rnw_a | input | 1 | Producer access select, 0 = write |
| din_a | input | DATA_W | Word to store |
| af_n | output | 1 | Almost-full flag, active low, on `clk_a` |
| ofs_af | input | ADDR_W | Almost-full offset `m` |
| clk_b | input | 1 | Consumer-side clock |
| en_b | input | 1 | Consumer access enable |
| rnw_b | input | 1 | Consumer access select, 1 = read |
| dout_b | output | DATA_W | Last word read |
| ae_n | output | 1 | Almost-empty flag, active low, on `clk_b` |
| ofs_ae | input | ADDR_W | Almost-empty offset `n` |

## Verification
The bench fills the queue to its full depth. It then tries a write while full and, after draining, a read while empty. A design that let either access through would show a stray word or a changed `dout_b`.

Both flags are checked at their exact threshold crossings with offsets 4 and 3. A design with an off-by-one compare would flip a flag one word early or late. The bench also counts how many edges each cross-domain flag release takes, which catches a missing or extra synchroniser stage.

Finally, the two clocks run at unrelated rates, and both sides are throttled only by their own flags. Data is compared against a queue model, so a binary (non-Gray) pointer crossing or a flag that reports too early would show up as corrupted or repeated words.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

    localparam int WORD_W  = 18;
    localparam int PTR_MAX = 16;

    function automatic logic [PTR_MAX-1:0] gray_to_bin(input logic [PTR_MAX-1:0] g);
        logic [PTR_MAX-1:0] b;
        b[PTR_MAX-1] = g[PTR_MAX-1];
        for (int i = PTR_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/dcfifo_mem.sv
module dcfifo_mem #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 8
) (
    input  logic              clk_w,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              clk_r,
    input  logic              rst_n,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_ff @(posedge clk_w) begin
        if (we) cells[waddr] <= wdata;
    end

    always_comb begin
        rdata_d = rdata_q;
        if (re) rdata_d = cells[raddr];
    end

    always_ff @(posedge clk_r or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W:0]   rgray_s,
    input  logic [ADDR_W-1:0] ofs_af,
    output logic [ADDR_W:0]   wbin,
    output logic [ADDR_W:0]   wgray,
    output logic              wr_fire,
    output logic              full,
    output logic              af_n
);
    localparam int PW    = ADDR_W + 1;
    localparam int PM    = dcfifo_pkg::PTR_MAX;
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          af_n;
    } wst_t;

    wst_t          st_d, st_q;
    logic [PW-1:0] rbin_s, used, used_d, limit;
    logic          full_c, fire_c;

    always_comb begin
        st_d      = st_q;
        rbin_s    = PW'(dcfifo_pkg::gray_to_bin(PM'(rgray_s)));
        used      = st_q.bin - rbin_s;
        full_c    = (used == PW'(DEPTH));
        fire_c    = wr_req && !full_c;
        st_d.bin  = st_q.bin + PW'(fire_c);
        st_d.gray = st_d.bin ^ (st_d.bin >> 1);
        used_d    = st_d.bin - rbin_s;
        limit     = PW'(DEPTH) - PW'(ofs_af);
        st_d.af_n = !(used_d >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{bin: '0, gray: '0, af_n: 1'b1};
        else        st_q <= st_d;
    end

    assign wbin    = st_q.bin;
    assign wgray   = st_q.gray;
    assign wr_fire = fire_c;
    assign full    = full_c;
    assign af_n    = st_q.af_n;
endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W:0]   wgray_s,
    input  logic [ADDR_W-1:0] ofs_ae,
    output logic [ADDR_W:0]   rbin,
    output logic [ADDR_W:0]   rgray,
    output logic              rd_fire,
    output logic              empty,
    output logic              ae_n
);
    localparam int PW = ADDR_W + 1;
    localparam int PM = dcfifo_pkg::PTR_MAX;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          ae_n;
    } rst_t;

    rst_t          st_d, st_q;
    logic [PW-1:0] wbin_s, avail, avail_d;
    logic          empty_c, fire_c;

    always_comb begin
        st_d      = st_q;
        wbin_s    = PW'(dcfifo_pkg::gray_to_bin(PM'(wgray_s)));
        avail     = wbin_s - st_q.bin;
        empty_c   = (avail == '0);
        fire_c    = rd_req && !empty_c;
        st_d.bin  = st_q.bin + PW'(fire_c);
        st_d.gray = st_d.bin ^ (st_d.bin >> 1);
        avail_d   = wbin_s - st_d.bin;
        st_d.ae_n = !(avail_d <= PW'(ofs_ae));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{bin: '0, gray: '0, ae_n: 1'b0};
        else        st_q <= st_d;
    end

    assign rbin    = st_q.bin;
    assign rgray   = st_q.gray;
    assign rd_fire = fire_c;
    assign empty   = empty_c;
    assign ae_n    = st_q.ae_n;
endmodule

// File: rtl/dcfifo_ab.sv
module dcfifo_ab #(
    parameter  int DATA_W = dcfifo_pkg::WORD_W,
    parameter  int DEPTH  = 256,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk_a,
    input  logic              rst_n,
    input  logic              en_a,
    input  logic              rnw_a,
    input  logic [DATA_W-1:0] din_a,
    output logic              af_n,
    input  logic [ADDR_W-1:0] ofs_af,
    input  logic              clk_b,
    input  logic              en_b,
    input  logic              rnw_b,
    output logic [DATA_W-1:0] dout_b,
    output logic              ae_n,
    input  logic [ADDR_W-1:0] ofs_ae
);
    logic [ADDR_W:0] w_bin, w_gray, r_bin, r_gray, w_gray_s, r_gray_s;
    logic            wr_req, rd_req, wr_fire, rd_fire, full, empty;

    assign wr_req = en_a && !rnw_a;
    assign rd_req = en_b && rnw_b;

    dcfifo_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
        .clk(clk_a), .rst_n(rst_n), .wr_req(wr_req), .rgray_s(r_gray_s),
        .ofs_af(ofs_af), .wbin(w_bin), .wgray(w_gray), .wr_fire(wr_fire),
        .full(full), .af_n(af_n)
    );

    dcfifo_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
        .clk(clk_b), .rst_n(rst_n), .rd_req(rd_req), .wgray_s(w_gray_s),
        .ofs_ae(ofs_ae), .rbin(r_bin), .rgray(r_gray), .rd_fire(rd_fire),
        .empty(empty), .ae_n(ae_n)
    );

    dcfifo_sync #(.W(ADDR_W + 1)) u_w2r (
        .clk(clk_b), .rst_n(rst_n), .d(w_gray), .q(w_gray_s)
    );

    dcfifo_sync #(.W(ADDR_W + 1)) u_r2w (
        .clk(clk_a), .rst_n(rst_n), .d(r_gray), .q(r_gray_s)
    );

    dcfifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk_w(clk_a), .we(wr_fire), .waddr(w_bin[ADDR_W-1:0]), .wdata(din_a),
        .clk_r(clk_b), .rst_n(rst_n), .re(rd_fire), .raddr(r_bin[ADDR_W-1:0]),
        .rdata(dout_b)
    );
endmodule

// File: rtl/dcfifo_ab_chk.sv
module dcfifo_ab_chk #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 8
) (
    input logic              clk_a,
    input logic              clk_b,
    input logic              rst_n,
    input logic              wr_req,
    input logic              wr_fire,
    input logic              full,
    input logic              rd_req,
    input logic              rd_fire,
    input logic              empty,
    input logic [ADDR_W:0]   w_bin,
    input logic [ADDR_W:0]   r_bin,
    input logic [ADDR_W:0]   w_gray,
    input logic [ADDR_W:0]   r_gray,
    input logic [DATA_W-1:0] dout_b
);
    localparam int PW = ADDR_W + 1;

    p_write_step_r1: assert property (@(posedge clk_a) disable iff (!rst_n)
        wr_fire |=> (w_bin == $past(w_bin) + PW'(1)));

    p_read_step_r2: assert property (@(posedge clk_b) disable iff (!rst_n)
        rd_fire |=> (r_bin == $past(r_bin) + PW'(1)));

    p_no_overflow_r3: assert property (@(posedge clk_a) disable iff (!rst_n)
        (wr_req && full) |=> (w_bin == $past(w_bin)));

    p_no_underflow_r4: assert property (@(posedge clk_b) disable iff (!rst_n)
        (rd_req && empty) |=> (r_bin == $past(r_bin)));

    p_dout_hold_r4: assert property (@(posedge clk_b) disable iff (!rst_n)
        !rd_fire |=> $stable(dout_b));

    p_wgray_step_r8: assert property (@(posedge clk_a) disable iff (!rst_n)
        $countones(w_gray ^ $past(w_gray)) <= 1);

    p_rgray_step_r8: assert property (@(posedge clk_b) disable iff (!rst_n)
        $countones(r_gray ^ $past(r_gray)) <= 1);
endmodule

bind dcfifo_ab dcfifo_ab_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .wr_req(wr_req), .wr_fire(wr_fire), .full(full),
    .rd_req(rd_req), .rd_fire(rd_fire), .empty(empty),
    .w_bin(w_bin), .r_bin(r_bin), .w_gray(w_gray), .r_gray(r_gray),
    .dout_b(dout_b)
);

// File: tb/dcfifo_ab_tb.sv
`timescale 1ns/1ps
module dcfifo_ab_tb;
    localparam int DEPTH = 256;
    localparam int AW    = 8;
    localparam int N_AE  = 4;
    localparam int M_AF  = 3;
    localparam int TOTAL = 600;

    logic          clk_a = 0, clk_b = 0, rst_n = 0;
    logic          en_a = 0, rnw_a = 0, en_b = 0, rnw_b = 0;
    logic [17:0]   din_a = '0;
    logic [17:0]   dout_b;
    logic          ae_n, af_n;
    logic [AW-1:0] ofs_ae = AW'(N_AE);
    logic [AW-1:0] ofs_af = AW'(M_AF);

    int checks = 0, errors = 0;
    int na_cnt = 0, nb_cnt = 0;
    int na_snap = 0, nb_snap = 0;
    int rx_cnt = 0;
    bit mon_pend = 0;
    bit done = 0;
    bit wr_done = 0;
    logic [17:0] exp_q[$];

    dcfifo_ab #(.DEPTH(DEPTH)) u_dut (
        .clk_a(clk_a), .rst_n(rst_n), .en_a(en_a), .rnw_a(rnw_a), .din_a(din_a),
        .af_n(af_n), .ofs_af(ofs_af), .clk_b(clk_b), .en_b(en_b), .rnw_b(rnw_b),
        .dout_b(dout_b), .ae_n(ae_n), .ofs_ae(ofs_ae)
    );

    always #4 clk_a = ~clk_a;
    initial begin
        #0.5;
        forever #5.55 clk_b = ~clk_b;
    end

    always @(posedge clk_a) na_cnt++;
    always @(posedge clk_b) nb_cnt++;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: compares each accepted read against the scoreboard
    always @(negedge clk_b) begin
        if (mon_pend) begin
            mon_pend = 0;
            if (exp_q.size() == 0) begin
                chk(0, "R2", "read with empty model", {14'd0, dout_b}, 32'hffffffff);
            end else begin
                logic [17:0] e;
                e = exp_q.pop_front();
                chk(dout_b == e, "R2", "read data order", {14'd0, dout_b}, {14'd0, e});
            end
            rx_cnt++;
        end
    end

    task automatic wr_word(input logic [17:0] d, input bit push);
        @(negedge clk_a);
        en_a = 1; rnw_a = 0; din_a = d;
        @(posedge clk_a);
        nb_snap = nb_cnt;
        if (push) exp_q.push_back(d);
        @(negedge clk_a);
        en_a = 0;
    endtask

    task automatic rd_word(input bit expect_data);
        @(negedge clk_b);
        en_b = 1; rnw_b = 1;
        @(posedge clk_b);
        na_snap = na_cnt;
        if (expect_data) mon_pend = 1;
        @(negedge clk_b);
        en_b = 0;
    endtask

    task automatic settle();
        repeat (6) @(posedge clk_a);
        repeat (6) @(posedge clk_b);
        @(negedge clk_a);
    endtask

    task automatic wait_ae_rise(input int nb0, output int lat);
        lat = -1;
        for (int i = 0; i < 10; i++) begin
            if (ae_n) begin lat = nb_cnt - nb0; break; end
            @(posedge clk_b); #1;
        end
    endtask

    task automatic wait_af_rise(input int na0, output int lat);
        lat = -1;
        for (int i = 0; i < 10; i++) begin
            if (af_n) begin lat = na_cnt - na0; break; end
            @(posedge clk_a); #1;
        end
    endtask

    initial begin
        int lvl;
        int lat;
        logic [17:0] last;

        #20;
        chk(ae_n == 1'b0, "R9", "ae_n in reset", {31'd0, ae_n}, 0);
        chk(af_n == 1'b1, "R9", "af_n in reset", {31'd0, af_n}, 1);
        #10 rst_n = 1;
        settle();

        lvl = 0;
        for (int i = 0; i < N_AE; i++) begin
            wr_word(18'h100 + 18'(i), 1);
            lvl++;
            chk(af_n == 1'b1, "R7", "af_n after low write", {31'd0, af_n}, 1);
        end
        settle();
        chk(ae_n == 1'b0, "R5", "ae_n at count n", {31'd0, ae_n}, 0);

        // R1: an access with rnw_a=1 must not store a word
        @(negedge clk_a); en_a = 1; rnw_a = 1; din_a = 18'h3ffff;
        @(negedge clk_a); en_a = 0; rnw_a = 0;
        settle();
        chk(ae_n == 1'b0, "R1", "ae_n after rnw_a=1 access", {31'd0, ae_n}, 0);

        // R8: write to n+1, measure ae_n release in clk_b edges
        wr_word(18'h100 + 18'(lvl), 1);
        lvl++;
        wait_ae_rise(nb_snap, lat);
        chk(lat == 3 || lat == 4, "R8", "ae_n release latency", 32'(lat), 3);
        settle();
        chk(ae_n == 1'b1, "R5", "ae_n at count n+1", {31'd0, ae_n}, 1);

        // fill to full, af_n checked at each write edge
        while (lvl < DEPTH) begin
            wr_word(18'h100 + 18'(lvl), 1);
            lvl++;
            chk(af_n == ((lvl >= DEPTH - M_AF) ? 1'b0 : 1'b1), "R6",
                "af_n right after write", {31'd0, af_n},
                (lvl >= DEPTH - M_AF) ? 0 : 1);
        end

        // R3: write into a full queue is dropped
        wr_word(18'h0dead, 0);
        settle();
        chk(af_n == 1'b0, "R3", "af_n after write on full", {31'd0, af_n}, 0);

        // drain, ae_n checked at each read edge
        while (lvl > 0) begin
            rd_word(1);
            lvl--;
            chk(ae_n == ((lvl <= N_AE) ? 1'b0 : 1'b1), "R7", "ae_n right after read",
                {31'd0, ae_n}, (lvl <= N_AE) ? 0 : 1);
            if (lvl == DEPTH - M_AF - 1) begin
                wait_af_rise(na_snap, lat);
                chk(lat == 3 || lat == 4, "R8", "af_n release latency", 32'(lat), 3);
            end
        end
        settle();
        chk(af_n == 1'b1, "R6", "af_n when empty", {31'd0, af_n}, 1);
        chk(exp_q.size() == 0, "R3", "scoreboard left over", 32'(exp_q.size()), 0);

        // R4: read on empty
        last = dout_b;
        rd_word(0);
        settle();
        chk(dout_b == last, "R4", "dout_b after read on empty", {14'd0, dout_b}, {14'd0, last});
        chk(ae_n == 1'b0, "R4", "ae_n after read on empty", {31'd0, ae_n}, 0);

        // unrelated clocks, both sides throttled by their own flag
        rx_cnt = 0;
        fork
            begin
                for (int i = 0; i < TOTAL; i++) begin
                    while (!af_n) @(negedge clk_a);
                    wr_word(18'($urandom), 1);
                    if (($urandom % 4) == 0) repeat ($urandom % 5) @(negedge clk_a);
                end
                wr_done = 1;
            end
            begin
                while (rx_cnt < TOTAL) begin
                    if (ae_n) begin
                        rd_word(1);
                        if (($urandom % 3) == 0) repeat ($urandom % 4) @(negedge clk_b);
                    end else if (wr_done) begin
                        settle();
                        while (rx_cnt + (mon_pend ? 1 : 0) < TOTAL) rd_word(1);
                        @(negedge clk_b);
                    end else begin
                        @(negedge clk_b);
                    end
                end
            end
        join
        chk(rx_cnt == TOTAL, "R2", "words received", 32'(rx_cnt), 32'(TOTAL));
        chk(exp_q.size() == 0, "R8", "scoreboard after crossing run", 32'(exp_q.size()), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog R2 actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule